// File: doc/BRIEF.md
# Double-Buffered Output Update Control

This block holds the two-level register storage behind a pair of 16-bit converter channels. Each channel has an input register, which the serial front end fills, and an output register, which drives the converter. A finished write arrives as a one-cycle commit pulse with a channel address and a data word. The pulse comes in the first cycle after the active-low frame-select line returns high. The block decides when each output register takes a new value.

The active-low load strobe chooses how updates happen. The block samples the strobe when a frame opens. If the strobe is low at that point, the addressed output follows its input at commit. If it is high, the outputs keep their values until the strobe next falls. That falling edge copies every input register into its output register at once. A falling edge that arrives while a frame is still open is held back until the frame has committed. Both frame-select and the strobe are sampled as synchronous levels on the system clock.

Top module: `dbuf_update_ctrl`

## Requirements
- R1: A commit writes wr_data into the input register of every channel it addresses. Address 0 is channel 0 and address 1 is channel 1. The result is visible on in_regs (channel c at bits [16c+15:16c]) in the cycle after the commit.
- R2: In per-channel mode (load_n low in the cycle frame_n first goes low), a commit loads wr_data into the addressed output register, visible on out_regs in the cycle after the commit.
- R3: In deferred mode (load_n high in the cycle frame_n first goes low), a commit leaves every output register unchanged.
- R4: A falling edge of load_n while frame_n is high and no commit is present copies every input register into its output register, visible on the next cycle.
- R5: The mode is fixed when frame_n falls and holds for the whole frame. Raising load_n during a per-channel frame still updates the output at commit.
- R6: A load_n falling edge seen while frame_n is low, or in a commit cycle, is held. It is applied as a copy of all channels in the first later cycle with frame_n high and no commit, so the copy includes the just-committed data.
- R7: Address 7 selects every channel. It writes the data into all input registers and, in per-channel mode, into all output registers.
- R8: After reset, every input and output register holds midscale 0x8000, and upd is 0.
- R9: upd[c] is high for exactly one cycle, in the same cycle that output register c shows a newly loaded value. It is low in every other cycle.
- R10: A commit with an address that matches no channel and is not 7 (codes 2 to 6) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Frame-select level, low while a frame is shifted |
| load_n | input | 1 | Active-low load strobe level |
| wr_commit | input | 1 | One-cycle pulse carrying a completed write |
| wr_addr | input | 3 | Channel address of the write (7 = all) |
| wr_data | input | 16 | Data word of the write |
| in_regs | output | 32 | Input registers, channel c at [16c+15:16c] |
| out_regs | output | 32 | Output registers, channel c at [16c+15:16c] |
| upd | output | 2 | Per-channel pulse marking an output register load |

## Verification
The bench raises load_n partway through a per-channel frame. A design that samples the strobe level at commit instead of at frame start would then leave the output stale. It also lowers the strobe partway through a deferred frame. A design that drops that edge never copies the new data, and a design that applies it at once copies the old input value one cycle early. The bench also covers the broadcast address in both modes, unmatched addresses that must leave every register alone, and the count of update pulses per channel, which catches a missing pulse or a pulse on the wrong channel.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic {
        UPD_EACH = 1'b0,
        UPD_BULK = 1'b1
    } upd_mode_e;

    typedef struct packed {
        upd_mode_e mode;
        logic      pend;
    } mode_state_t;

endpackage

// File: rtl/dbuf_edge.sv
module dbuf_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~lvl;

endmodule

// File: rtl/dbuf_mode.sv
module dbuf_mode
    import dbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_n,
    input  logic      load_n,
    input  logic      frame_fall,
    input  logic      load_fall,
    input  logic      wr_commit,
    output upd_mode_e mode,
    output logic      load_all
);

    mode_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d = st_q;
        fire = (st_q.pend || load_fall) && frame_n && !wr_commit;
        if (frame_fall)
            st_d.mode = load_n ? UPD_BULK : UPD_EACH;
        if (fire)
            st_d.pend = 1'b0;
        else if (load_fall)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: UPD_EACH, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign load_all = fire;

    AST_NO_COPY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> !load_all); // R6
    AST_HELD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && !frame_n) |=> (st_q.pend || load_all)); // R6
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !frame_fall) |=> $stable(mode)); // R5

endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan
    import dbuf_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 3,
    parameter int IDX      = 0,
    parameter int ALL_CODE = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  upd_mode_e     mode,
    input  logic          load_all,
    output logic [DW-1:0] in_o,
    output logic [DW-1:0] out_o,
    output logic          upd_o
);

    localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);
    localparam logic [AW-1:0] MY_CODE  = AW'(IDX);
    localparam logic [AW-1:0] BC_CODE  = AW'(ALL_CODE);

    typedef struct packed {
        logic [DW-1:0] inr;
        logic [DW-1:0] outr;
        logic          upd;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      sel;

    always_comb begin
        sel        = wr_commit && (wr_addr == MY_CODE || wr_addr == BC_CODE);
        st_d       = st_q;
        st_d.upd   = 1'b0;
        if (sel)
            st_d.inr = wr_data;
        if (sel && mode == UPD_EACH) begin
            st_d.outr = wr_data;
            st_d.upd  = 1'b1;
        end else if (load_all) begin
            st_d.outr = st_q.inr;
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{inr: MIDSCALE, outr: MIDSCALE, upd: 1'b0};
        else        st_q <= st_d;
    end

    assign in_o  = st_q.inr;
    assign out_o = st_q.outr;
    assign upd_o = st_q.upd;

    AST_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && (wr_addr == MY_CODE || wr_addr == BC_CODE)) |=> in_o == $past(wr_data)); // R1
    AST_EACH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && mode == UPD_EACH && (wr_addr == MY_CODE || wr_addr == BC_CODE))
        |=> out_o == $past(wr_data)); // R2
    AST_BULK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && mode == UPD_BULK) |=> $stable(out_o)); // R3
    AST_BULK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load_all |=> out_o == $past(in_o)); // R4
    AST_UPD_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_o) |-> upd_o); // R9
    AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && wr_addr != MY_CODE && wr_addr != BC_CODE) |=> $stable(in_o)); // R10

endmodule

// File: rtl/dbuf_update_ctrl.sv
module dbuf_update_ctrl
    import dbuf_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int DW       = 16,
    parameter int AW       = 3,
    parameter int ALL_CODE = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n,
    input  logic                 load_n,
    input  logic                 wr_commit,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [NUM_CH*DW-1:0] in_regs,
    output logic [NUM_CH*DW-1:0] out_regs,
    output logic [NUM_CH-1:0]    upd
);

    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_fall;
    upd_mode_e       mode;
    logic            load_all;

    dbuf_edge #(.W(NPIN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({load_n, frame_n}),
        .fall (pin_fall)
    );

    dbuf_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .load_n    (load_n),
        .frame_fall(pin_fall[0]),
        .load_fall (pin_fall[1]),
        .wr_commit (wr_commit),
        .mode      (mode),
        .load_all  (load_all)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dbuf_chan #(
            .DW      (DW),
            .AW      (AW),
            .IDX     (c),
            .ALL_CODE(ALL_CODE)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_commit(wr_commit),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .mode     (mode),
            .load_all (load_all),
            .in_o     (in_regs[c*DW +: DW]),
            .out_o    (out_regs[c*DW +: DW]),
            .upd_o    (upd[c])
        );
    end

    AST_NO_UPDATE_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> upd == '0); // R8

endmodule

// File: tb/dbuf_update_ctrl_test.sv
`timescale 1ns/1ps
module dbuf_update_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        load_n = 1'b1;
    logic        wr_commit = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [31:0] in_regs, out_regs;
    logic [1:0]  upd;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dbuf_update_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .load_n(load_n),
        .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_regs(in_regs), .out_regs(out_regs), .upd(upd)
    );

    // behavioural reference model
    int m_in[2], m_out[2], m_upd[2];
    int m_pfrm, m_pld, m_mode, m_pend;
    int pulses[2];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_in[c] = 'h8000; m_out[c] = 'h8000; m_upd[c] = 0;
            end
            m_pfrm = 1; m_pld = 1; m_mode = 0; m_pend = 0;
        end else begin
            int ffall, lfall, old_in[2];
            ffall = (m_pfrm == 1 && frame_n == 1'b0) ? 1 : 0;
            lfall = (m_pld == 1 && load_n == 1'b0) ? 1 : 0;
            for (int c = 0; c < 2; c++) begin
                old_in[c] = m_in[c];
                m_upd[c] = 0;
            end
            for (int c = 0; c < 2; c++) begin
                if (wr_commit && (wr_addr == 3'(c) || wr_addr == 3'd7)) begin
                    m_in[c] = int'(wr_data);
                    if (m_mode == 0) begin
                        m_out[c] = int'(wr_data); m_upd[c] = 1;
                    end
                end
            end
            if ((lfall == 1 || m_pend == 1) && frame_n && !wr_commit) begin
                for (int c = 0; c < 2; c++) begin
                    m_out[c] = old_in[c]; m_upd[c] = 1;
                end
                m_pend = 0;
            end else if (lfall == 1) begin
                m_pend = 1;
            end
            if (ffall == 1) m_mode = load_n ? 1 : 0;
            m_pfrm = int'(frame_n);
            m_pld  = int'(load_n);
        end
        #1;
        for (int c = 0; c < 2; c++) begin
            chk("MODEL in_regs R1", int'(in_regs[c*16 +: 16]), m_in[c]);
            chk("MODEL out_regs R2 R3 R4", int'(out_regs[c*16 +: 16]), m_out[c]);
            chk("MODEL upd R9", int'(upd[c]), m_upd[c]);
            if (upd[c]) pulses[c]++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ld(input logic v);
        @(negedge clk) load_n = v;
        idle(2);
    endtask

    // frame: opens with load_n = ld_start, optional mid-frame change,
    // returns at the negedge right after the commit edge
    task automatic frame(input logic ld_start, input int mid, input logic [2:0] a,
                         input logic [15:0] d);
        @(negedge clk); frame_n = 1'b0; load_n = ld_start;
        idle(2);
        if (mid >= 0) load_n = mid[0];
        idle(2);
        frame_n = 1'b1; wr_commit = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_commit = 1'b0; wr_data = 16'hDEAD;
    endtask

    function automatic int ch_in(input int c);  return int'(in_regs[c*16 +: 16]);  endfunction
    function automatic int ch_out(input int c); return int'(out_regs[c*16 +: 16]); endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 in0", ch_in(0), 'h8000);   chk("R8 in1", ch_in(1), 'h8000);
        chk("R8 out0", ch_out(0), 'h8000); chk("R8 out1", ch_out(1), 'h8000);
        chk("R8 upd", int'(upd), 0);

        // R2 per-channel update, R9 pulse count
        set_ld(1'b0);
        idle(2);
        pulses[0] = 0; pulses[1] = 0;
        frame(1'b0, -1, 3'd0, 16'h1234);
        chk("R2 out0 after commit", ch_out(0), 'h1234);
        chk("R1 in0", ch_in(0), 'h1234);
        chk("R2 out1 untouched", ch_out(1), 'h8000);
        idle(2);
        chk("R9 pulses ch0", pulses[0], 1);
        chk("R9 pulses ch1", pulses[1], 0);

        // R3 deferred, then R4 bulk copy
        set_ld(1'b1);
        frame(1'b1, -1, 3'd1, 16'hABCD);
        idle(2);
        chk("R3 out1 held", ch_out(1), 'h8000);
        chk("R1 in1 deferred", ch_in(1), 'hABCD);
        pulses[0] = 0; pulses[1] = 0;
        set_ld(1'b0);
        chk("R4 out1 copied", ch_out(1), 'hABCD);
        chk("R4 out0 copied", ch_out(0), 'h1234);
        chk("R9 bulk pulses", pulses[0] + pulses[1], 2);

        // R5 mode frozen at frame start (raise strobe mid-frame)
        frame(1'b0, 1, 3'd0, 16'h5555);
        chk("R5 out0 immediate", ch_out(0), 'h5555);
        idle(2);

        // R6 held edge: strobe falls inside a deferred frame
        frame(1'b1, 0, 3'd1, 16'h7777);
        chk("R6 out1 not yet", ch_out(1), 'hABCD);
        @(negedge clk);
        chk("R6 out1 after held copy", ch_out(1), 'h7777);
        idle(2);

        // R7 broadcast, per-channel mode
        frame(1'b0, -1, 3'd7, 16'h0F0F);
        chk("R7 out0", ch_out(0), 'h0F0F); chk("R7 out1", ch_out(1), 'h0F0F);
        // R7 broadcast, deferred mode
        set_ld(1'b1);
        frame(1'b1, -1, 3'd7, 16'h3C3C);
        idle(2);
        chk("R7 deferred out0", ch_out(0), 'h0F0F);
        chk("R7 deferred in1", ch_in(1), 'h3C3C);
        set_ld(1'b0);
        chk("R7 copy out0", ch_out(0), 'h3C3C); chk("R7 copy out1", ch_out(1), 'h3C3C);

        // R10 unmatched addresses
        for (int a = 2; a < 7; a++) begin
            frame(1'b0, -1, 3'(a), 16'hFFFF);
        end
        idle(2);
        chk("R10 in0", ch_in(0), 'h3C3C);   chk("R10 in1", ch_in(1), 'h3C3C);
        chk("R10 out0", ch_out(0), 'h3C3C); chk("R10 out1", ch_out(1), 'h3C3C);

        // reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 out0 re-reset", ch_out(0), 'h8000);
        chk("R8 in1 re-reset", ch_in(1), 'h8000);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule